// File: doc/BRIEF.md
# Eight-Input Interrupt Controller with Two-Address Register Port

This block collects eight interrupt request lines, remembers which are waiting and which are being serviced, and drives one interrupt line toward a processor. Software reaches it through a byte-wide port with a single address bit. Address 0 accepts the first setup word and the run-time commands, and returns whichever status view the last command picked. Address 1 accepts the remaining setup words and otherwise holds the interrupt mask.

A rising edge on a request line marks that line pending. A one-cycle acknowledge strobe hands the lowest-numbered unmasked pending line to service and presents its vector (the programmed base with the line index in the low three bits). Software ends service with either an end-of-interrupt command that releases every in-service line or one that names a single line. Reads have no side effects, and all register updates take effect on the clock edge of the access.

Top module: `pic8_regport`

## Requirements
- R1: After reset the pending, in-service and mask registers are 0x00, `irq_out` is low, `vec_out` is 0x00, address-0 reads use the poll format, and the vector base is 0x00 (or 0x08 when `SECONDARY` is 1).
- R2: An address-0 write with bit 4 set starts setup; the next address-1 write is taken as the base word, and its bits 7..3 become the vector base (bits 2..0 dropped); the mask is left unchanged by it.
- R3: With setup word 1 bit 1 = 0 a cascade word follows the base word and is discarded; with bit 0 = 1 a final word follows after that; once the last word is taken, address-1 writes load the mask.
- R4: With setup word 1 bit 1 = 1 the cascade word is skipped; with bit 0 = 0 the final word is skipped, so setup ends right after the last required word.
- R5: An address-0 write with bit 4 clear aborts any unfinished setup and is then decoded as a command.
- R6: A 0-to-1 change on `irq_in[i]` sets pending bit i on that clock edge; a line held high does not set the bit again.
- R7: Command 0x0A makes address-0 reads return the pending register, 0x0B the in-service register, 0x0C the poll format; the poll format is 0x80 OR the index of the lowest set pending bit (mask not applied), or 0x00 when none is set.
- R8: Address-1 reads return the mask; `irq_out` is high exactly when some pending bit is set whose mask bit is clear, updated on the edge that changes either register.
- R9: When `ack_in` is high and an unmasked request is pending, the lowest such index moves from pending to in-service and `vec_out` becomes base OR index on that edge; with nothing unmasked pending, the strobe changes nothing; only this path sets in-service bits.
- R10: Command 0x20 clears every pending bit that is also in service, then clears all in-service bits.
- R11: Commands 0x21..0x27, 0x60..0x67 and 0xE0..0xE7 clear the pending and in-service bit whose index is the command's bits 2..0.
- R12: Any other command with bit 4 clear (for example 0x68 or 0xC3) changes no register and no read selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable; gates `bus_rdata` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0x00 when not reading |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| ack_in | input | 1 | Acknowledge strobe from the processor |
| vec_out | output | 8 | Vector of the last acknowledged request |
| irq_out | output | 1 | Interrupt request toward the processor |

## Verification
A wrong pending or mask bit shows on `irq_out` one edge after the offending event, and the bench compares that line and `vec_out` against its model every cycle, so such faults surface within one clock. A wrong in-service bit or vector base stays hidden until the next acknowledge or a status read; the sequence therefore reads the pending and in-service views after each command and acknowledges under three different bases. A stuck setup phase appears as the next mask write being swallowed, which a mask read-back right after every setup variant exposes.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int unsigned IRQ_N = 8;
  localparam int unsigned IDX_W = $clog2(IRQ_N);
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BASE = 2'd1,
    PH_CASC = 2'd2,
    PH_LAST = 2'd3
  } setup_ph_t;

  typedef enum logic [1:0] {
    VIEW_POLL = 2'd0,
    VIEW_PEND = 2'd1,
    VIEW_SERV = 2'd2
  } view_t;

  typedef struct packed {
    logic             view_ld;
    view_t            view;
    logic             eoi_all;
    logic             eoi_one;
    logic [IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/pic_cmd_decode.sv
`timescale 1ns/1ps
module pic_cmd_decode
  import pic_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output cmd_t              cmd
);
  logic [BYTE_W-IDX_W-1:0] hi;
  logic                    lo_nz;

  always_comb begin
    hi    = code[BYTE_W-1:IDX_W];
    lo_nz = |code[IDX_W-1:0];
    cmd   = '0;
    cmd.idx = code[IDX_W-1:0];
    unique case (code)
      8'h0A: begin cmd.view_ld = 1'b1; cmd.view = VIEW_PEND; end
      8'h0B: begin cmd.view_ld = 1'b1; cmd.view = VIEW_SERV; end
      8'h0C: begin cmd.view_ld = 1'b1; cmd.view = VIEW_POLL; end
      8'h20: cmd.eoi_all = 1'b1;
      default: begin
        cmd.eoi_one = ((hi == 5'b00100) && lo_nz) ||
                      (hi == 5'b01100) || (hi == 5'b11100);
      end
    endcase
  end
endmodule

// File: rtl/pic_setup_seq.sv
`timescale 1ns/1ps
module pic_setup_seq
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      abort,
  input  logic      step,
  input  logic      cfg_single,
  input  logic      cfg_last,
  output setup_ph_t phase,
  output logic      base_ld,
  output logic      busy
);
  setup_ph_t ph_q, ph_d;
  logic      single_q, single_d;
  logic      last_q, last_d;
  logic      cfg_en;

  always_comb begin
    ph_d     = ph_q;
    cfg_en   = start;
    single_d = cfg_single;
    last_d   = cfg_last;
    if (start) begin
      ph_d = PH_BASE;
    end else if (abort) begin
      ph_d = PH_IDLE;
    end else if (step) begin
      unique case (ph_q)
        PH_BASE: ph_d = !single_q ? PH_CASC : (last_q ? PH_LAST : PH_IDLE);
        PH_CASC: ph_d = last_q ? PH_LAST : PH_IDLE;
        PH_LAST: ph_d = PH_IDLE;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      single_q <= 1'b0;
      last_q   <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (cfg_en) begin
        single_q <= single_d;
        last_q   <= last_d;
      end
    end
  end

  assign phase   = ph_q;
  assign busy    = (ph_q != PH_IDLE);
  assign base_ld = step && !start && !abort && (ph_q == PH_BASE);
endmodule

// File: rtl/pic_lowest.sv
`timescale 1ns/1ps
module pic_lowest #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [N-1:0] onehot
);
  logic [N-1:0] seen;

  always_comb begin
    seen[0] = 1'b0;
    for (int i = 1; i < N; i++) seen[i] = seen[i-1] | req[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pick
      assign onehot[g] = req[g] & ~seen[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) if (onehot[i]) idx = idx | W'(i);
  end

  assign any = |req;
endmodule

// File: rtl/pic8_regport.sv
`timescale 1ns/1ps
module pic8_regport
  import pic_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [IRQ_N-1:0]  irq_in,
  input  logic              ack_in,
  output logic [BYTE_W-1:0] vec_out,
  output logic              irq_out
);
  localparam int unsigned BASE_W = BYTE_W - IDX_W;
  localparam logic [BASE_W-1:0] BASE_RST = SECONDARY ? BASE_W'(1) : '0;

  logic [IRQ_N-1:0]  pend_q, pend_d, serv_q, serv_d, mask_q, prev_q;
  logic [BASE_W-1:0] base_q;
  logic [BYTE_W-1:0] vec_q, vec_d;
  view_t             view_q;
  cmd_t              cmd;
  setup_ph_t         phase;
  logic              base_ld, busy;
  logic              wr0, wr1, start, cmd_wr, mask_en, view_en, vec_en;
  logic [IRQ_N-1:0]  rise, cmd_onehot, pend_clr, serv_clr;
  logic              poll_any, ack_any, ack_go;
  logic [IDX_W-1:0]  poll_idx, ack_idx;
  logic [IRQ_N-1:0]  poll_oh, ack_oh;
  logic [BYTE_W-1:0] view_data;

  assign wr0    = bus_wr && !bus_addr;
  assign wr1    = bus_wr && bus_addr;
  assign start  = wr0 && bus_wdata[4];
  assign cmd_wr = wr0 && !bus_wdata[4];

  pic_cmd_decode u_dec (.code(bus_wdata), .cmd(cmd));

  pic_setup_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(cmd_wr), .step(wr1),
    .cfg_single(bus_wdata[1]), .cfg_last(bus_wdata[0]),
    .phase(phase), .base_ld(base_ld), .busy(busy)
  );

  pic_lowest #(.N(IRQ_N)) u_poll (
    .req(pend_q), .any(poll_any), .idx(poll_idx), .onehot(poll_oh)
  );

  pic_lowest #(.N(IRQ_N)) u_pick (
    .req(pend_q & ~mask_q), .any(ack_any), .idx(ack_idx), .onehot(ack_oh)
  );

  always_comb begin
    rise       = irq_in & ~prev_q;
    cmd_onehot = IRQ_N'(1) << cmd.idx;
    ack_go     = ack_in && ack_any;
    mask_en    = wr1 && !busy;
    view_en    = cmd_wr && cmd.view_ld;
    vec_en     = ack_go;
    vec_d      = {base_q, ack_idx};
    pend_clr   = '0;
    serv_clr   = '0;
    if (cmd_wr && cmd.eoi_all) begin
      pend_clr = serv_q;
      serv_clr = '1;
    end else if (cmd_wr && cmd.eoi_one) begin
      pend_clr = cmd_onehot;
      serv_clr = cmd_onehot;
    end
    if (ack_go) pend_clr = pend_clr | ack_oh;
    pend_d = (pend_q & ~pend_clr) | rise;
    serv_d = (serv_q & ~serv_clr) | (ack_go ? ack_oh : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      serv_q <= '0;
      mask_q <= '0;
      prev_q <= '0;
      base_q <= BASE_RST;
      vec_q  <= '0;
      view_q <= VIEW_POLL;
    end else begin
      pend_q <= pend_d;
      serv_q <= serv_d;
      prev_q <= irq_in;
      if (mask_en) mask_q <= bus_wdata;
      if (base_ld) base_q <= bus_wdata[BYTE_W-1:IDX_W];
      if (vec_en)  vec_q  <= vec_d;
      if (view_en) view_q <= cmd.view;
    end
  end

  always_comb begin
    unique case (view_q)
      VIEW_PEND: view_data = pend_q;
      VIEW_SERV: view_data = serv_q;
      default:   view_data = poll_any ? {1'b1, {(BYTE_W-IDX_W-1){1'b0}}, poll_idx} : '0;
    endcase
  end

  assign bus_rdata = !bus_rd ? '0 : (bus_addr ? mask_q : view_data);
  assign vec_out   = vec_q;
  assign irq_out   = |(pend_q & ~mask_q);
endmodule

// File: rtl/pic8_regport_chk.sv
`timescale 1ns/1ps
module pic8_regport_chk
  import pic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              ack_in,
  input logic [BYTE_W-1:0] vec_out,
  input logic              irq_out,
  input logic [IRQ_N-1:0]  pend,
  input logic [IRQ_N-1:0]  serv,
  input logic [IRQ_N-1:0]  mask,
  input setup_ph_t         phase
);
  // R2: a setup word 1 always leads to the base-word phase
  p_setup_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && bus_wdata[4] |=> phase == PH_BASE);

  // R8: masking every line silences the output on the next edge
  p_full_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr && (phase == PH_IDLE) && (bus_wdata == 8'hFF) |=> !irq_out);

  // R9: an acknowledged line is in service afterwards
  p_ack_in_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_in && !bus_wr && |(pend & ~mask) |=> serv[vec_out[IDX_W-1:0]]);

  // R9: no new in-service bit appears without a strobe
  p_serv_only_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_in |=> (serv & ~$past(serv)) == '0);

  // R10: the release-all command empties in-service
  p_eoi_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && (bus_wdata == 8'h20) && !ack_in |=> serv == '0);

  // R11: a specific release in the 0x60 group clears its line
  p_eoi_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && (bus_wdata[7:3] == 5'b01100) && !ack_in
    |=> !serv[$past(bus_wdata[2:0])]);
endmodule

bind pic8_regport pic8_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .ack_in(ack_in), .vec_out(vec_out), .irq_out(irq_out),
  .pend(pend_q), .serv(serv_q), .mask(mask_q), .phase(phase)
);

// File: tb/tb_pic8_regport.sv
`timescale 1ns/1ps
module tb_pic8_regport;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, irq_in, vec_out;
  logic       ack_in, irq_out;
  logic [7:0] s_irq, s_rdata, s_vec;
  logic       s_ack, s_int;

  int checks = 0;
  int errs   = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  pic8_regport dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .ack_in(ack_in),
    .vec_out(vec_out), .irq_out(irq_out)
  );

  pic8_regport #(.SECONDARY(1'b1)) dut_sec (
    .clk(clk), .rst_n(rst_n), .bus_addr(1'b0), .bus_wr(1'b0), .bus_rd(1'b0),
    .bus_wdata(8'h00), .bus_rdata(s_rdata), .irq_in(s_irq), .ack_in(s_ack),
    .vec_out(s_vec), .irq_out(s_int)
  );

  // behavioural reference model of the primary instance
  logic [7:0] m_irr, m_isr, m_mask, m_base, m_vec, m_prev;
  int m_ph;
  bit m_single, m_last;

  always @(posedge clk) begin
    logic [7:0] n_irr, n_isr, pend;
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_base = 0; m_vec = 0; m_prev = 0;
      m_ph = 0; m_single = 0; m_last = 0;
    end else begin
      n_irr = m_irr; n_isr = m_isr;
      pend = m_irr & ~m_mask;
      if (ack_in && pend != 0) begin
        for (int i = 7; i >= 0; i--) if (pend[i]) m_vec = m_base | 8'(i);
        n_irr[m_vec[2:0]] = 1'b0;
        n_isr[m_vec[2:0]] = 1'b1;
      end
      if (bus_wr && !bus_addr) begin
        if (bus_wdata[4]) begin
          m_ph = 1; m_single = bus_wdata[1]; m_last = bus_wdata[0];
        end else begin
          m_ph = 0;
          if (bus_wdata == 8'h20) begin
            n_irr = n_irr & ~m_isr; n_isr = 0;
          end else if ((bus_wdata >= 8'h21 && bus_wdata <= 8'h27) ||
                       (bus_wdata >= 8'h60 && bus_wdata <= 8'h67) ||
                       (bus_wdata >= 8'hE0 && bus_wdata <= 8'hE7)) begin
            n_irr[bus_wdata[2:0]] = 1'b0; n_isr[bus_wdata[2:0]] = 1'b0;
          end
        end
      end
      if (bus_wr && bus_addr) begin
        case (m_ph)
          0: m_mask = bus_wdata;
          1: begin m_base = bus_wdata & 8'hF8; m_ph = !m_single ? 2 : (m_last ? 3 : 0); end
          2: m_ph = m_last ? 3 : 0;
          default: m_ph = 0;
        endcase
      end
      m_irr = n_irr | (irq_in & ~m_prev);
      m_isr = n_isr;
      m_prev = irq_in;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      chk({7'd0, irq_out}, {7'd0, |(m_irr & ~m_mask)}, "R8 irq_out vs model");
      chk(vec_out, m_vec, "R9 vec_out vs model");
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 chk(bus_rdata, exp, tag);
    bus_rd = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ack_in = 1'b1;
    @(posedge clk); #1 ack_in = 1'b0;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(posedge clk); #1;
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    irq_in = 0; ack_in = 0; s_irq = 0; s_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    chk({7'd0, irq_out}, 8'h00, "R1 irq_out reset");
    chk(vec_out, 8'h00, "R1 vec_out reset");
    rd(1'b1, 8'h00, "R1 mask reset");
    rd(1'b0, 8'h00, "R1 poll view reset");

    // R1: secondary instance base
    @(negedge clk); s_irq = 8'h01;
    @(negedge clk); chk({7'd0, s_int}, 8'h01, "R1 secondary irq_out");
    s_ack = 1'b1;
    @(negedge clk); s_ack = 1'b0;
    chk(s_vec, 8'h08, "R1 secondary base vector");

    // R2/R3: full setup with cascade and final word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h25);
    rd(1'b1, 8'h00, "R2 base word leaves mask");
    wr(1'b1, 8'h04);
    rd(1'b1, 8'h00, "R3 cascade word discarded");
    wr(1'b1, 8'h01);
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R3 mask after setup");

    // R6/R7/R8
    lines(8'h24);
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h24, "R6 edges set pending");
    rd(1'b0, 8'h24, "R7 pending view");
    @(negedge clk); chk({7'd0, irq_out}, 8'h01, "R8 unmasked pending");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h82, "R7 poll lowest");

    // R9 acknowledge
    ack();
    @(negedge clk); chk(vec_out, 8'h22, "R9 vector base|idx");
    chk({7'd0, irq_out}, 8'h00, "R8 remaining masked");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h04, "R9 in-service view");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R9 pending cleared");

    // R10: re-raise line 2 then release all
    lines(8'h20);
    lines(8'h24);
    rd(1'b0, 8'h24, "R6 re-raise");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h20, "R10 pending in-service cleared");
    lines(8'h24);
    rd(1'b0, 8'h20, "R6 held line no re-set");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R10 in-service empty");

    // R12: ignored commands
    wr(1'b0, 8'h0A);
    wr(1'b0, 8'h68);
    wr(1'b0, 8'hC3);
    rd(1'b0, 8'h20, "R12 ignored commands");

    // R11: specific releases
    wr(1'b0, 8'h65);
    rd(1'b0, 8'h00, "R11 0x65 clears pending");
    wr(1'b1, 8'h00);
    lines(8'h25);
    ack();
    @(negedge clk); chk(vec_out, 8'h20, "R9 line 0 vector");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h01, "R9 line 0 in service");
    wr(1'b0, 8'hE0);
    rd(1'b0, 8'h00, "R11 0xE0 releases");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R7 poll none");
    ack();
    @(negedge clk); chk(vec_out, 8'h20, "R9 idle strobe");

    // R4: single mode, no final word
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h48);
    wr(1'b1, 8'h7F);
    rd(1'b1, 8'h7F, "R4 single no final");
    lines(8'hA5);
    ack();
    @(negedge clk); chk(vec_out, 8'h4F, "R4 new base");
    wr(1'b0, 8'h27);

    // R4: cascade without final word
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h55);
    rd(1'b1, 8'h55, "R4 cascade no final");

    // R5: abort
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h0B);
    wr(1'b1, 8'h3C);
    rd(1'b1, 8'h3C, "R5 abort then mask");
    rd(1'b0, 8'h00, "R5 command decoded");
    lines(8'hA7);
    ack();
    @(negedge clk); chk(vec_out, 8'h81, "R5 base kept");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule